// File: doc/BRIEF.md
# Conversion Result Output Mode Controller

This block hands a finished conversion result (a 12-bit magnitude count, a polarity flag and an overrange flag) to a host. It has two ways of doing so. In direct mode the host reads the newest result one byte at a time: a chip enable gates the output, and two byte enables choose which half appears on the byte-wide bus. In handshake mode the block sends the result by itself as two bytes, low byte first. Each byte is offered with a valid strobe, and the host accepts it by raising SEND.

A MODE input chooses between the two. While MODE is low, the block stays in direct mode. A rising edge on MODE asks for one handshake transfer: the request waits for the next end-of-conversion event, sends that result, and then the block returns to direct mode. While MODE is held high, every end-of-conversion event starts a transfer.

The handshake side is a valid/ready stream. `byte_valid` is valid and `send` is ready. A byte is transferred on a rising clock edge where both are high. While `byte_valid` is high and `send` is low, the block holds `bus_data` stable and keeps offering the same byte. `byte_valid` never drops without a transfer. The result being sent sits in its own holding register, so conversions that finish during a transfer do not disturb it.

Top module: `conv_out_ctrl`

## Requirements
- R1: After reset, `bus_oe` and `byte_valid` are low and `bus_data` is zero.
- R2: When idle, `bus_oe` equals `chip_en` AND (`ben_lo` OR `ben_hi`). `ben_lo` selects the low byte (count bits 7:0). `ben_hi` selects the high byte: bits 3:0 are count bits 11:8, bit 6 is polarity, bit 7 is overrange, and bits 5:4 are zero. When both enables are high, the low byte wins. While `bus_oe` is low, `bus_data` is zero.
- R3: A `conv_done` pulse captures the result into the direct-read latch. The new value can be read in the cycle after the capturing edge.
- R4: While MODE is low and no request is pending, `conv_done` starts no transfer, and SEND has no effect while idle.
- R5: A rising edge on MODE leaves a pending request. The next `conv_done` starts exactly one two-byte transfer, and later events with MODE low start none.
- R6: While MODE is high, every `conv_done` that finds the block idle starts a two-byte transfer.
- R7: A transfer offers the low byte and then the high byte, each with `byte_valid` high. It advances only on an edge where `send` is high. While `send` is low, the data stays stable.
- R8: The bytes of a transfer are the result captured when it started. A `conv_done` during a transfer neither changes them nor starts a new transfer, but it does update the direct-read latch.
- R9: During a transfer, `bus_oe` is high and `chip_en` and the byte enables are ignored.
- R10: A MODE rising edge that arrives during a transfer stays pending and is served by the first `conv_done` after the transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_done | input | 1 | One-cycle end-of-conversion event |
| conv_count | input | 12 | Conversion magnitude count |
| conv_pol | input | 1 | Polarity of the result |
| conv_ovr | input | 1 | Overrange flag |
| mode_in | input | 1 | Output mode select (low, pulse, held high) |
| send | input | 1 | Handshake ready from host |
| chip_en | input | 1 | Direct-mode output enable, active high |
| ben_lo | input | 1 | Direct-mode low byte select |
| ben_hi | input | 1 | Direct-mode high byte select |
| bus_data | output | 8 | Byte-wide output data |
| bus_oe | output | 1 | Output-enable for the bus driver |
| byte_valid | output | 1 | Handshake byte valid strobe |

## Verification
A corrupted transfer state or byte-select flag appears at the ports at once, in the next cycle, as a wrong byte order, a lost or repeated byte, or data that changes while SEND is low. The scoreboard compares every accepted byte with the queue. A request flag that is lost or never cleared shows up only at the next end-of-conversion event, as a missing or extra two-byte transfer. A holding register that tracks the live result shows up only when a conversion ends in the middle of a stalled transfer, so the bench stalls SEND deliberately around such events.

// File: rtl/omc_pkg.sv
package omc_pkg;
  typedef enum logic [2:0] {
    XS_IDLE = 3'b001,
    XS_LO   = 3'b010,
    XS_HI   = 3'b100
  } xfer_state_e;
endpackage

// File: rtl/omc_mode_req.sv
module omc_mode_req (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_in,
  input  logic start,
  output logic req
);
  logic mode_q;
  logic pend_q;
  logic rise;

  assign rise = mode_in & ~mode_q;
  assign req  = mode_in | pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_in;
      if (start)     pend_q <= 1'b0;
      else if (rise) pend_q <= 1'b1;
    end
  end

  // R5: a served request is consumed
  p_pend_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !pend_q);
  // R10: an edge that is not served stays pending
  p_pend_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !start) |=> pend_q);
endmodule

// File: rtl/omc_result_regs.sv
module omc_result_regs #(
  parameter int CNT_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [CNT_W-1:0]  conv_count,
  input  logic              conv_pol,
  input  logic              conv_ovr,
  input  logic              load_hold,
  output logic [BYTE_W-1:0] dir_lo,
  output logic [BYTE_W-1:0] dir_hi,
  output logic [BYTE_W-1:0] hs_lo,
  output logic [BYTE_W-1:0] hs_hi
);
  localparam int HI_CNT = CNT_W - BYTE_W;
  localparam int REC_W  = CNT_W + 2;

  logic [REC_W-1:0] live_q;
  logic [REC_W-1:0] hold_q;
  logic [REC_W-1:0] incoming;

  assign incoming = {conv_ovr, conv_pol, conv_count};

  function automatic logic [BYTE_W-1:0] low_of(logic [REC_W-1:0] r);
    return r[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] high_of(logic [REC_W-1:0] r);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[HI_CNT-1:0] = r[CNT_W-1:BYTE_W];
    b[BYTE_W-2]   = r[CNT_W];
    b[BYTE_W-1]   = r[CNT_W+1];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      hold_q <= '0;
    end else begin
      if (conv_done) live_q <= incoming;
      if (load_hold) hold_q <= incoming;
    end
  end

  assign dir_lo = low_of(live_q);
  assign dir_hi = high_of(live_q);
  assign hs_lo  = low_of(hold_q);
  assign hs_hi  = high_of(hold_q);

  // R8: the held record changes only when a transfer starts
  p_hold_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_hold |=> $stable(hold_q));
endmodule

// File: rtl/omc_hs_fsm.sv
module omc_hs_fsm
  import omc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic send,
  output logic idle,
  output logic byte_valid,
  output logic sel_hi
);
  xfer_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      XS_IDLE: if (start) st_d = XS_LO;
      XS_LO:   if (send)  st_d = XS_HI;
      XS_HI:   if (send)  st_d = XS_IDLE;
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= XS_IDLE;
    else        st_q <= st_d;
  end

  assign idle       = (st_q == XS_IDLE);
  assign byte_valid = !idle;
  assign sel_hi     = (st_q == XS_HI);

  // R7: low byte goes first, then high byte, advancing only on send
  p_lo_to_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !sel_hi && send) |=> (byte_valid && sel_hi));
  p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !send) |=> (byte_valid && $stable(sel_hi)));
  // R4: SEND does nothing while idle
  p_idle_send_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |=> idle);
endmodule

// File: rtl/omc_direct_mux.sv
module omc_direct_mux #(
  parameter int BYTE_W = 8
) (
  input  logic              chip_en,
  input  logic              ben_lo,
  input  logic              ben_hi,
  input  logic [BYTE_W-1:0] lo_byte,
  input  logic [BYTE_W-1:0] hi_byte,
  output logic              oe,
  output logic [BYTE_W-1:0] data
);
  always_comb begin
    oe   = chip_en & (ben_lo | ben_hi);
    data = '0;
    if (chip_en) begin
      if (ben_lo)      data = lo_byte;
      else if (ben_hi) data = hi_byte;
    end
  end
endmodule

// File: rtl/conv_out_ctrl.sv
module conv_out_ctrl #(
  parameter int CNT_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [CNT_W-1:0]  conv_count,
  input  logic              conv_pol,
  input  logic              conv_ovr,
  input  logic              mode_in,
  input  logic              send,
  input  logic              chip_en,
  input  logic              ben_lo,
  input  logic              ben_hi,
  output logic [BYTE_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              byte_valid
);
  logic              req, start, idle, sel_hi;
  logic              dir_oe;
  logic [BYTE_W-1:0] dir_lo, dir_hi, hs_lo, hs_hi, dir_data;

  assign start = conv_done & req & idle;

  omc_mode_req u_req (
    .clk(clk), .rst_n(rst_n), .mode_in(mode_in), .start(start), .req(req)
  );

  omc_result_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_res (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_count(conv_count),
    .conv_pol(conv_pol), .conv_ovr(conv_ovr), .load_hold(start),
    .dir_lo(dir_lo), .dir_hi(dir_hi), .hs_lo(hs_lo), .hs_hi(hs_hi)
  );

  omc_hs_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .send(send),
    .idle(idle), .byte_valid(byte_valid), .sel_hi(sel_hi)
  );

  omc_direct_mux #(.BYTE_W(BYTE_W)) u_dir (
    .chip_en(chip_en), .ben_lo(ben_lo), .ben_hi(ben_hi),
    .lo_byte(dir_lo), .hi_byte(dir_hi), .oe(dir_oe), .data(dir_data)
  );

  always_comb begin
    if (idle) begin
      bus_oe   = dir_oe;
      bus_data = dir_data;
    end else begin
      bus_oe   = 1'b1;
      bus_data = sel_hi ? hs_hi : hs_lo;
    end
  end

  // R7: a stalled byte stays put on the bus
  p_stall_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !send) |=> (byte_valid && $stable(bus_data)));
  // R9: a handshake byte is always driven
  p_valid_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> bus_oe);
  // R2: without chip enable the idle bus is released
  p_direct_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_valid && !chip_en) |-> (!bus_oe && bus_data == '0));
  // R8: a conversion ending mid-transfer does not restart it
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !send && conv_done) |=> $stable(bus_data));
endmodule

// File: tb/tb_conv_out_ctrl.sv
module tb_conv_out_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [11:0] conv_count = '0;
  logic        conv_pol = 1'b0, conv_ovr = 1'b0;
  logic        mode_in = 1'b0, send = 1'b0;
  logic        chip_en = 1'b0, ben_lo = 1'b0, ben_hi = 1'b0;
  logic [7:0]  bus_data;
  logic        bus_oe, byte_valid;

  int compared = 0, mismatched = 0;
  int send_pat = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  conv_out_ctrl dut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_count(conv_count),
    .conv_pol(conv_pol), .conv_ovr(conv_ovr), .mode_in(mode_in), .send(send),
    .chip_en(chip_en), .ben_lo(ben_lo), .ben_hi(ben_hi),
    .bus_data(bus_data), .bus_oe(bus_oe), .byte_valid(byte_valid)
  );

  function automatic logic [7:0] hi_exp(logic [11:0] c, logic p, logic o);
    return {o, p, 2'b00, c[11:8]};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // SEND generator: 0 high, 1 every third cycle, 2 low, 3 toggling
  always @(negedge clk) begin
    cyc <= cyc + 1;
    case (send_pat)
      0: send <= 1'b1;
      1: send <= (cyc % 3 == 0);
      2: send <= 1'b0;
      default: send <= ~send;
    endcase
  end

  // Monitor: scoreboard pop on each accepted byte, stall stability check
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (prev_stall) begin
          check("R7 stall-stable", {byte_valid, 7'b0}, 8'h80);
          check("R7 stall-data", bus_data, prev_data);
        end
        if (byte_valid && send) begin
          if (exp_q.size() == 0) check("R4/R5 unexpected byte", bus_data, 8'hxx);
          else check("R7/R8 byte", bus_data, exp_q.pop_front());
        end
        prev_stall = byte_valid && !send;
        prev_data  = bus_data;
      end
    end
  end

  task automatic do_conv(logic [11:0] c, logic p, logic o, bit xfer);
    @(negedge clk);
    conv_count = c; conv_pol = p; conv_ovr = o; conv_done = 1'b1;
    if (xfer) begin
      exp_q.push_back(c[7:0]);
      exp_q.push_back(hi_exp(c, p, o));
    end
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (exp_q.size() != 0 || byte_valid);
  endtask

  task automatic read_dir(string tag, logic ce, logic lo, logic hi,
                          logic [7:0] exp, logic exp_oe);
    @(negedge clk);
    chip_en = ce; ben_lo = lo; ben_hi = hi;
    #1;
    check({tag, " data"}, bus_data, exp);
    check({tag, " oe"}, {7'b0, bus_oe}, {7'b0, exp_oe});
    chip_en = 0; ben_lo = 0; ben_hi = 0;
  endtask

  task automatic pulse_mode();
    @(negedge clk); mode_in = 1'b1;
    @(negedge clk); mode_in = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 data", bus_data, 8'h00);
    check("R1 oe/valid", {6'b0, bus_oe, byte_valid}, 8'h00);
    rst_n = 1'b1;

    // R2/R3 direct reads
    do_conv(12'hA5C, 1'b1, 1'b0, 1'b0);
    read_dir("R3 R2 low", 1, 1, 0, 8'h5C, 1);
    read_dir("R2 high", 1, 0, 1, 8'h4A, 1);
    read_dir("R2 both", 1, 1, 1, 8'h5C, 1);
    read_dir("R2 no-ce", 0, 1, 1, 8'h00, 0);
    do_conv(12'h7E3, 1'b0, 1'b1, 1'b0);
    read_dir("R3 update high", 1, 0, 1, 8'h87, 1);

    // R4 MODE low: no transfer, SEND ignored
    send_pat = 3;
    do_conv(12'h123, 1'b0, 1'b0, 1'b0);
    repeat (4) begin
      @(negedge clk); #1;
      check("R4 idle valid", {7'b0, byte_valid}, 8'h00);
    end
    read_dir("R4 latch after send", 1, 1, 0, 8'h23, 1);

    // R5 single pulse -> one transfer
    send_pat = 0;
    pulse_mode();
    repeat (3) @(negedge clk);
    #1 check("R5 waits for conv", {7'b0, byte_valid}, 8'h00);
    do_conv(12'h3F1, 1'b0, 1'b1, 1'b1);
    drain();
    do_conv(12'h555, 1'b1, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    #1 check("R5 back to direct", {7'b0, byte_valid}, 8'h00);

    // R6 held high, with back-pressure
    send_pat = 1;
    @(negedge clk); mode_in = 1'b1;
    do_conv(12'h9AB, 1'b1, 1'b0, 1'b1); drain();
    do_conv(12'h0FF, 1'b0, 1'b0, 1'b1); drain();
    do_conv(12'hC01, 1'b1, 1'b1, 1'b1); drain();

    // R8/R9 conversion during stalled transfer, enables ignored
    send_pat = 2;
    do_conv(12'h246, 1'b0, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    do_conv(12'hBCD, 1'b1, 1'b0, 1'b0);
    @(negedge clk); chip_en = 0; ben_lo = 0; ben_hi = 1; #1;
    check("R9 oe forced", {7'b0, bus_oe}, 8'h01);
    check("R8 R9 held low byte", bus_data, 8'h46);
    ben_hi = 0;
    @(negedge clk); mode_in = 1'b0;
    send_pat = 0;
    drain();
    read_dir("R8 latch newest", 1, 1, 0, 8'hCD, 1);

    // R10 edge during transfer stays pending
    send_pat = 2;
    pulse_mode();
    do_conv(12'h812, 1'b0, 1'b0, 1'b1);
    pulse_mode();
    repeat (2) @(negedge clk);
    send_pat = 0;
    drain();
    do_conv(12'h6A9, 1'b1, 1'b1, 1'b1);
    drain();
    do_conv(12'h111, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    #1 check("R10 single service", {7'b0, byte_valid}, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule